// File: doc/BRIEF.md
# Dual-Register Modulating NCO Core

This block is the digital heart of a direct-synthesis signal source. A 28-bit phase accumulator advances once per master clock by one of two stored tuning words, so the output frequency is f_clk × word / 2^28. A choice between the two tuning words gives frequency-shift keying without a phase jump. A choice between two stored 12-bit phase offsets, added to the top of the accumulator, gives phase-shift keying in steps of 2π/4096. The truncated 12-bit phase becomes a 10-bit converter code: either an offset-binary sine from a table built at elaboration, or a symmetric triangle.

Each of the three run-time controls (tuning-word select, offset select, accumulator clear) comes either from a dedicated pin or from a configuration bit, depending on a source-mode input. A freeze input stops the phase and holds the code. A separate one-bit square-wave output carries the accumulator's top bit, either directly or halved in frequency, and can be silenced. Tuning words and offsets are loaded through a simple parallel write port. The functional clear does not touch them. Only the chip reset does.

The datapath runs through six register stages: control capture, word fetch, accumulate, offset add, shaping, and the output register. Every select change or clear release therefore reaches the code on the sixth rising edge.

Top module: `nco_mod_core`

## Requirements
- R1: While running, the accumulator adds the selected 28-bit tuning word every cycle and wraps modulo 2^28. With word 2^27 in triangle mode, the code alternates between 0 and 1023.
- R2: Select value 0 picks tuning word 0 and value 1 picks tuning word 1. After a select change, the code's per-cycle step keeps its old value through the fifth rising edge and takes the new value on the sixth, with no phase reset.
- R3: The selected offset (select 0 → offset 0, 1 → offset 1) is added to accumulator bits 27:16 to form the 12-bit phase p. After an offset-select change, the new code appears on the sixth rising edge.
- R4: In sine mode (ramp_mode=0), code = 512 + round(511·sin(2π·p/4096)). The code therefore lies in 1..1023, and p=0 gives 512.
- R5: In triangle mode (ramp_mode=1), code = p[10:1] when p[11]=0 and ~p[10:1] when p[11]=1. p=0 gives 0.
- R6: While clear is active, the accumulator holds zero, so the sine code is 512. After clear is released, the code first moves on the sixth rising edge. Tuning words and offsets survive a clear.
- R7: While hold is 1, neither the accumulator nor the code changes. When hold drops, the code continues at the next step.
- R8: With pin_mode=1, the three controls come from the *_pin inputs and the *_bit inputs are ignored. With pin_mode=0, the reverse applies.
- R9: With sq_direct=1, sq_out follows accumulator bit 27. With sq_direct=0, it toggles on each rising transition of that bit, which halves the frequency.
- R10: With sq_en=0, sq_out is 0.
- R11: After rst_n, the code is 512, sq_out is 0, and both tuning words and both offsets are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low chip reset |
| wr_en | input | 1 | Write strobe for the register file |
| wr_target | input | 2 | 0 word0, 1 word1, 2 offset0, 3 offset1 |
| wr_data | input | 28 | Write data (offsets use bits 11:0) |
| pin_mode | input | 1 | 1: controls from pins, 0: from bits |
| fsel_pin | input | 1 | Tuning-word select, pin source |
| psel_pin | input | 1 | Offset select, pin source |
| clr_pin | input | 1 | Accumulator clear, pin source |
| fsel_bit | input | 1 | Tuning-word select, bit source |
| psel_bit | input | 1 | Offset select, bit source |
| clr_bit | input | 1 | Accumulator clear, bit source |
| hold | input | 1 | Freeze accumulator and code |
| ramp_mode | input | 1 | 1: triangle, 0: sine |
| sq_en | input | 1 | Square output enable |
| sq_direct | input | 1 | 1: direct top bit, 0: halved |
| dac_code | output | 10 | Converter code |
| sq_out | output | 1 | Square-wave output |

## Verification
Select changes and clear release are due exactly on the sixth rising edge. The bench changes inputs one time unit after an edge, then samples after each of the following edges. It checks that the fifth sample still shows the old behaviour and the sixth shows the new one. Hold takes effect on the very first edge, and the code resumes on the first edge after hold drops. Steady-state values (sine points, triangle points, wrap) are sampled eight or more cycles after a register write, by which point the whole pipeline has refilled. Square-wave checks count transitions over whole windows of 64 cycles.

// File: rtl/nco_pkg.sv
package nco_pkg;
    localparam int ACC_W = 28;
    localparam int PH_W  = 12;
    localparam int DAC_W = 10;

    typedef enum logic [1:0] {
        WR_WORD0 = 2'd0,
        WR_WORD1 = 2'd1,
        WR_OFS0  = 2'd2,
        WR_OFS1  = 2'd3
    } wr_target_e;

    typedef struct packed {
        logic fsel;
        logic psel;
        logic clr;
    } ctl_t;
endpackage

// File: rtl/nco_accum.sv
module nco_accum #(
    parameter int ACC_W = 28,
    parameter int PH_W  = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             clr,
    input  logic [ACC_W-1:0] inc,
    input  logic [PH_W-1:0]  ofs,
    input  logic             sq_en,
    input  logic             sq_direct,
    output logic [PH_W-1:0]  phase,
    output logic             sq_out
);
    logic [ACC_W-1:0] acc;
    logic [PH_W-1:0]  ofs_d;
    logic             msb_prev;
    logic             half_q;

    // stage 3: accumulate, offset delayed to line up with it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc   <= '0;
            ofs_d <= '0;
        end else if (en) begin
            acc   <= clr ? '0 : acc + inc;
            ofs_d <= ofs;
        end
    end

    // stage 4: phase offset added to the top bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (en) begin
            phase <= acc[ACC_W-1 -: PH_W] + ofs_d;
        end
    end

    // square output: top bit, or its halved version
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            msb_prev <= 1'b0;
            half_q   <= 1'b0;
        end else if (en) begin
            msb_prev <= acc[ACC_W-1];
            if (acc[ACC_W-1] && !msb_prev) begin
                half_q <= ~half_q;
            end
        end
    end

    assign sq_out = sq_en && (sq_direct ? acc[ACC_W-1] : half_q);

    assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && clr) |=> (acc == '0))
        else $error("accumulator not cleared");
endmodule

// File: rtl/nco_shaper.sv
module nco_shaper #(
    parameter int PH_W  = 12,
    parameter int DAC_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             ramp,
    input  logic [PH_W-1:0]  phase,
    output logic [DAC_W-1:0] code
);
    localparam int QN    = 2 ** (PH_W - 2);
    localparam int MAG_W = DAC_W - 1;
    localparam int AMP   = 2 ** (DAC_W - 1) - 1;
    localparam logic [DAC_W-1:0] MID_V = {1'b1, {(DAC_W-1){1'b0}}};
    localparam logic [PH_W-2:0]  QN_V  = {1'b1, {(PH_W-2){1'b0}}};

    function automatic logic [(QN+1)*MAG_W-1:0] build_quarter();
        logic [(QN+1)*MAG_W-1:0] v;
        real a;
        int  m;
        v = '0;
        for (int i = 0; i <= QN; i++) begin
            a = real'(AMP) * $sin(6.283185307179586 * real'(i) / real'(4 * QN));
            m = $rtoi(a + 0.5);
            v[i*MAG_W +: MAG_W] = m[MAG_W-1:0];
        end
        return v;
    endfunction

    localparam logic [(QN+1)*MAG_W-1:0] QTAB = build_quarter();

    logic [1:0]       quad;
    logic [PH_W-2:0]  idx;
    logic [MAG_W-1:0] mag;
    logic [DAC_W-1:0] sine_v;
    logic [DAC_W-1:0] tri_v;
    logic [DAC_W-1:0] lut_q;

    always_comb begin
        quad   = phase[PH_W-1 -: 2];
        idx    = quad[0] ? (QN_V - {1'b0, phase[PH_W-3:0]}) : {1'b0, phase[PH_W-3:0]};
        mag    = QTAB[idx*MAG_W +: MAG_W];
        sine_v = quad[1] ? (MID_V - {1'b0, mag}) : (MID_V + {1'b0, mag});
        tri_v  = phase[PH_W-1] ? ~phase[PH_W-2 -: DAC_W] : phase[PH_W-2 -: DAC_W];
    end

    // stage 5: shaping, stage 6: output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lut_q <= MID_V;
            code  <= MID_V;
        end else if (en) begin
            lut_q <= ramp ? tri_v : sine_v;
            code  <= lut_q;
        end
    end

    assert_sine_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !ramp) |=> (lut_q != '0))
        else $error("sine code out of range");

    assert_tri_origin_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ramp && phase == '0) |=> (lut_q == '0))
        else $error("triangle does not start at zero");
endmodule

// File: rtl/nco_mod_core.sv
module nco_mod_core
    import nco_pkg::*;
#(
    parameter int ACC_W_P = ACC_W,
    parameter int PH_W_P  = PH_W,
    parameter int DAC_W_P = DAC_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_target,
    input  logic [ACC_W_P-1:0] wr_data,
    input  logic               pin_mode,
    input  logic               fsel_pin,
    input  logic               psel_pin,
    input  logic               clr_pin,
    input  logic               fsel_bit,
    input  logic               psel_bit,
    input  logic               clr_bit,
    input  logic               hold,
    input  logic               ramp_mode,
    input  logic               sq_en,
    input  logic               sq_direct,
    output logic [DAC_W_P-1:0] dac_code,
    output logic               sq_out
);
    logic [ACC_W_P-1:0] word_r [2];
    logic [PH_W_P-1:0]  ofs_r  [2];
    ctl_t               ctl_q;
    logic [ACC_W_P-1:0] inc_q;
    logic [PH_W_P-1:0]  ofs_q;
    logic               clr_q;
    logic [PH_W_P-1:0]  phase;
    logic               run_en;

    assign run_en = ~hold;

    // register file: cleared by chip reset only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_r[0] <= '0;
            word_r[1] <= '0;
            ofs_r[0]  <= '0;
            ofs_r[1]  <= '0;
        end else if (wr_en) begin
            unique case (wr_target_e'(wr_target))
                WR_WORD0: word_r[0] <= wr_data;
                WR_WORD1: word_r[1] <= wr_data;
                WR_OFS0:  ofs_r[0]  <= wr_data[PH_W_P-1:0];
                WR_OFS1:  ofs_r[1]  <= wr_data[PH_W_P-1:0];
            endcase
        end
    end

    // stage 1: capture controls from the chosen source
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= pin_mode ? ctl_t'{fsel_pin, psel_pin, clr_pin}
                              : ctl_t'{fsel_bit, psel_bit, clr_bit};
        end
    end

    // stage 2: fetch the selected word and offset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inc_q <= '0;
            ofs_q <= '0;
            clr_q <= 1'b0;
        end else begin
            inc_q <= word_r[ctl_q.fsel];
            ofs_q <= ofs_r[ctl_q.psel];
            clr_q <= ctl_q.clr;
        end
    end

    nco_accum #(.ACC_W(ACC_W_P), .PH_W(PH_W_P)) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (run_en),
        .clr       (clr_q),
        .inc       (inc_q),
        .ofs       (ofs_q),
        .sq_en     (sq_en),
        .sq_direct (sq_direct),
        .phase     (phase),
        .sq_out    (sq_out)
    );

    nco_shaper #(.PH_W(PH_W_P), .DAC_W(DAC_W_P)) u_shaper (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (run_en),
        .ramp  (ramp_mode),
        .phase (phase),
        .code  (dac_code)
    );

    assert_hold_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(dac_code))
        else $error("code moved while held");
endmodule

// File: tb/tb_nco_mod_core.sv
module tb_nco_mod_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_target = '0;
    logic [27:0] wr_data = '0;
    logic        pin_mode = 1'b0, fsel_pin = 1'b0, psel_pin = 1'b0, clr_pin = 1'b0;
    logic        fsel_bit = 1'b0, psel_bit = 1'b0, clr_bit = 1'b0;
    logic        hold = 1'b0, ramp_mode = 1'b0, sq_en = 1'b0, sq_direct = 1'b0;
    logic [9:0]  dac_code;
    logic        sq_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    nco_mod_core dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_target(wr_target), .wr_data(wr_data),
        .pin_mode(pin_mode), .fsel_pin(fsel_pin), .psel_pin(psel_pin), .clr_pin(clr_pin),
        .fsel_bit(fsel_bit), .psel_bit(psel_bit), .clr_bit(clr_bit), .hold(hold),
        .ramp_mode(ramp_mode), .sq_en(sq_en), .sq_direct(sq_direct),
        .dac_code(dac_code), .sq_out(sq_out)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] tgt, input logic [27:0] d);
        wr_en = 1'b1; wr_target = tgt; wr_data = d;
        step(1);
        wr_en = 1'b0;
    endtask

    function automatic int sine_exp(input int p);
        real a;
        a = 511.0 * $sin(6.283185307179586 * real'(p) / 4096.0);
        return 512 + $rtoi($floor(a + 0.5));
    endfunction

    task automatic restart();
        clr_bit = 1'b1; step(8);
        clr_bit = 1'b0;
    endtask

    task automatic t_reset();
        chk("R11 code after reset", int'(dac_code), 512);
        chk("R11 square after reset", int'(sq_out), 0);
        step(10);
        chk("R11 words cleared, code still midscale", int'(dac_code), 512);
    endtask

    task automatic t_release();
        wr(0, 28'h1 << 16);
        clr_bit = 1'b1; step(8);
        chk("R6 code while cleared", int'(dac_code), 512);
        clr_bit = 1'b0;
        step(5);
        chk("R6 edge5 after release", int'(dac_code), 512);
        step(1);
        chk("R6 edge6 after release", int'(dac_code), sine_exp(1));
        step(1);
        chk("R1 second step", int'(dac_code), sine_exp(2));
    endtask

    task automatic t_sine_points();
        int pts[5] = '{512, 1536, 2560, 1024, 3072};
        wr(0, 28'h0);
        restart();
        psel_bit = 1'b1;
        foreach (pts[i]) begin
            wr(3, 28'(pts[i]));
            step(8);
            chk("R4 sine at offset", int'(dac_code), sine_exp(pts[i]));
        end
        psel_bit = 1'b0;
    endtask

    task automatic t_psk();
        wr(0, 28'h0); wr(2, 28'h0); wr(3, 28'd1024);
        restart();
        psel_bit = 1'b0; step(8);
        chk("R3 offset0 code", int'(dac_code), 512);
        psel_bit = 1'b1;
        step(5);
        chk("R3 edge5 old offset", int'(dac_code), 512);
        step(1);
        chk("R3 edge6 new offset", int'(dac_code), 1023);
        psel_bit = 1'b0;
    endtask

    task automatic t_fsk();
        int prev;
        int d;
        ramp_mode = 1'b1;
        wr(0, 28'h2 << 16); wr(1, 28'h8 << 16); wr(2, 28'h0);
        fsel_bit = 1'b0;
        restart();
        step(20);
        prev = int'(dac_code);
        fsel_bit = 1'b1;
        for (int e = 1; e <= 7; e++) begin
            step(1);
            d = int'(dac_code) - prev;
            prev = int'(dac_code);
            if (e == 5) chk("R2 edge5 old step", d, 1);
            if (e == 6) chk("R2 edge6 new step", d, 4);
            if (e == 7) chk("R2 continuing new step", d, 4);
        end
        fsel_bit = 1'b0;
        ramp_mode = 1'b0;
    endtask

    task automatic t_ramp();
        int c1, c2, c3;
        ramp_mode = 1'b1;
        wr(0, 28'h0); wr(2, 28'd3072);
        restart(); step(8);
        chk("R5 triangle falling half", int'(dac_code), 511);
        wr(2, 28'd1000); step(8);
        chk("R5 triangle rising half", int'(dac_code), 500);
        wr(2, 28'h0); wr(0, 28'h1 << 27);
        restart(); step(8);
        c1 = int'(dac_code); step(1);
        c2 = int'(dac_code); step(1);
        c3 = int'(dac_code);
        chk("R1 wrap alternate", c2, 1023 - c1);
        chk("R1 wrap returns", c3, c1);
        ramp_mode = 1'b0;
    endtask

    task automatic t_hold();
        int v;
        ramp_mode = 1'b1;
        wr(0, 28'h2 << 16);
        restart(); step(10);
        hold = 1'b1;
        v = int'(dac_code);
        for (int e = 1; e <= 5; e++) begin
            step(1);
            chk("R7 held code", int'(dac_code), v);
        end
        hold = 1'b0;
        step(1);
        chk("R7 resume step", int'(dac_code), v + 1);
        step(1);
        chk("R7 resume continues", int'(dac_code), v + 2);
        ramp_mode = 1'b0;
    endtask

    task automatic t_pins();
        int a;
        wr(0, 28'h1 << 16);
        pin_mode = 1'b1; clr_pin = 1'b1; clr_bit = 1'b0;
        step(8);
        chk("R8 pin clear holds midscale", int'(dac_code), 512);
        step(4);
        chk("R8 bit clear ignored in pin mode", int'(dac_code), 512);
        ramp_mode = 1'b1;
        wr(0, 28'h2 << 16); wr(1, 28'h8 << 16);
        clr_pin = 1'b0; fsel_pin = 1'b0; fsel_bit = 1'b1;
        step(10);
        a = int'(dac_code); step(1);
        chk("R8 pin select used, bit ignored", int'(dac_code) - a, 1);
        pin_mode = 1'b0; clr_pin = 1'b1; fsel_bit = 1'b0; fsel_pin = 1'b1;
        step(10);
        a = int'(dac_code); step(1);
        chk("R8 pins ignored in bit mode", int'(dac_code) - a, 1);
        clr_pin = 1'b0; fsel_pin = 1'b0; ramp_mode = 1'b0;
    endtask

    task automatic t_square();
        int n;
        logic p;
        wr(0, 28'h1 << 24);
        restart();
        sq_en = 1'b1; sq_direct = 1'b1;
        step(4);
        n = 0; p = sq_out;
        for (int i = 0; i < 64; i++) begin
            step(1);
            if (sq_out != p) n++;
            p = sq_out;
        end
        chk("R9 direct transitions", n, 8);
        sq_direct = 1'b0;
        step(40);
        n = 0; p = sq_out;
        for (int i = 0; i < 64; i++) begin
            step(1);
            if (sq_out != p) n++;
            p = sq_out;
        end
        chk("R9 halved transitions", n, 4);
        sq_en = 1'b0;
        n = 0;
        for (int i = 0; i < 32; i++) begin
            step(1);
            if (sq_out) n++;
        end
        chk("R10 disabled square stays low", n, 0);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_release();
        t_sine_points();
        t_psk();
        t_fsk();
        t_ramp();
        t_hold();
        t_pins();
        t_square();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule